// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block handles the address phase of an I2C slave once a START or repeated START has been seen on the bus. A bit-level front end, which is not part of this block, hands it decoded bus events and each received byte. It compares the first byte after a START with a programmable own-address register and raises an addressed flag and a one-cycle ACK request when they match. In 10-bit mode it also stores the byte that follows a matching write header in a capture register, so that firmware can check the low address byte itself.

A control bit selects the addressing mode. In 7-bit mode the R/W position of the own-address register takes no part in the comparison. In 10-bit mode every bit of the first byte is compared, including the R/W position. Firmware checks the captured second byte and then sets the R/W position of the own-address register to 1. After that, a read header that arrives after a repeated START matches in hardware. A transfer-direction output tells the downstream data logic whether to transmit or receive.

Top module: `i2c_addr_match`

## Requirements
- R1: While and after reset, aas, ack_req and xfer_dir are 0, and every readable register returns 0x00.
- R2: In 7-bit mode (control bit 0 = 0), a header byte whose bits 7:1 equal own-address bits 7:1 counts as a match whatever the value of own-address bit 0. A match sets aas to 1, drives ack_req high for exactly the one cycle after the byte strobe, and loads xfer_dir with header bit 0.
- R3: In 10-bit mode (control bit 0 = 1), a header matches only if all 8 bits equal the own-address register, bit 0 included.
- R4: A header that does not match leaves aas at 0 and ack_req low. Every later byte is then ignored, with no ACK and no flag, until the next START or repeated START, which re-arms the comparison.
- R5: In 10-bit mode, the byte after a matching header with bit 0 = 0 is stored in the capture register (read address 3), and status bit 2 is set. The unit raises no ACK request for that byte.
- R6: After firmware writes own-address bit 0 = 1, a repeated START followed by the read header matches, sets xfer_dir to 1, and leaves the capture register unchanged.
- R7: A STOP clears aas. A START also clears aas, in the cycle after the START and before any new comparison.
- R8: A register write takes effect at the next clock edge. A header that arrives in the same cycle as the write is compared against the old value. Read data is registered, so it is valid one cycle after the read address is presented. Map: 0 = own address, 1 = control (bit 0 = 10-bit mode), 2 = status {bit 2 byte captured, bit 1 xfer_dir, bit 0 aas}, 3 = captured byte.
- R9: When events arrive in the same cycle, STOP wins over START or repeated START, and those win over the byte strobe. A byte strobe that loses is ignored.
- R10: Once a header has matched, the unit raises no ACK request for later bytes of the frame and aas stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | START detected (one-cycle strobe) |
| ev_rstart | input | 1 | Repeated START detected |
| ev_stop | input | 1 | STOP detected |
| ev_byte | input | 1 | Byte complete strobe |
| rx_byte | input | BYTE_W | Byte received from the bus |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | BYTE_W | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | BYTE_W | Registered read data |
| aas | output | 1 | Addressed-as-slave flag |
| ack_req | output | 1 | ACK request for the ninth clock, one cycle |
| xfer_dir | output | 1 | R/W bit of the last matched header |

## Verification
The bench builds the unit with the default byte width of 8. At that width every header value can be driven from the vector table: both R/W polarities, both addressing modes, and headers that differ from the own address only in bit 0. Directed sequences then cover the full 10-bit write, capture, firmware update and read flow, same-cycle event collisions, and a write that lands in the same cycle as a header.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_EXT,
    ST_DATA,
    ST_SKIP
  } am_state_t;

  localparam int RA_W = 2;
  localparam logic [RA_W-1:0] RA_OWN  = 2'd0;
  localparam logic [RA_W-1:0] RA_CTRL = 2'd1;
  localparam logic [RA_W-1:0] RA_STAT = 2'd2;
  localparam logic [RA_W-1:0] RA_CAP  = 2'd3;
endpackage

// File: rtl/i2c_am_regs.sv
module i2c_am_regs
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr,
  output logic [BYTE_W-1:0] rdata,
  input  logic              st_aas,
  input  logic              st_dir,
  input  logic              st_capv,
  input  logic [BYTE_W-1:0] cap_byte,
  output logic [BYTE_W-1:0] own_addr,
  output logic              ten_bit
);
  localparam int PAD_W = BYTE_W - 3;

  logic [BYTE_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= '0;
      ten_bit  <= 1'b0;
    end else if (we) begin
      if (waddr == RA_OWN)  own_addr <= wdata;
      if (waddr == RA_CTRL) ten_bit  <= wdata[0];
    end
  end

  always_comb begin
    case (raddr)
      RA_OWN:  rd_mux = own_addr;
      RA_CTRL: rd_mux = {{(BYTE_W-1){1'b0}}, ten_bit};
      RA_STAT: rd_mux = {{PAD_W{1'b0}}, st_capv, st_dir, st_aas};
      default: rd_mux = cap_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] hdr,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              ten_bit,
  output logic              hit
);
  logic hit_upper;
  logic hit_full;

  assign hit_upper = (hdr[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
  assign hit_full  = hit_upper && (hdr[0] == own_addr[0]);
  assign hit       = ten_bit ? hit_full : hit_upper;
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ten_bit,
  input  logic              hit,
  output logic              aas,
  output logic              ack_req,
  output logic              xfer_dir,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              cap_vld
);
  am_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      aas      <= 1'b0;
      ack_req  <= 1'b0;
      xfer_dir <= 1'b0;
      cap_byte <= '0;
      cap_vld  <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      if (ev_stop) begin
        state <= ST_IDLE;
        aas   <= 1'b0;
      end else if (ev_start) begin
        state   <= ST_HDR;
        aas     <= 1'b0;
        cap_vld <= 1'b0;
      end else if (ev_rstart) begin
        state <= ST_HDR;
      end else if (ev_byte) begin
        case (state)
          ST_HDR: begin
            aas     <= hit;
            ack_req <= hit;
            if (hit) begin
              xfer_dir <= rx_byte[0];
              state    <= (ten_bit && !rx_byte[0]) ? ST_EXT : ST_DATA;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_EXT: begin
            cap_byte <= rx_byte;
            cap_vld  <= 1'b1;
            state    <= ST_DATA;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_byte,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              reg_we,
  input  logic [1:0]        reg_waddr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [1:0]        reg_raddr,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              aas,
  output logic              ack_req,
  output logic              xfer_dir
);
  logic [BYTE_W-1:0] own_addr;
  logic              ten_bit;
  logic              hit;
  logic [BYTE_W-1:0] cap_byte;
  logic              cap_vld;

  i2c_am_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .waddr    (reg_waddr),
    .wdata    (reg_wdata),
    .raddr    (reg_raddr),
    .rdata    (reg_rdata),
    .st_aas   (aas),
    .st_dir   (xfer_dir),
    .st_capv  (cap_vld),
    .cap_byte (cap_byte),
    .own_addr (own_addr),
    .ten_bit  (ten_bit)
  );

  i2c_am_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .hdr      (rx_byte),
    .own_addr (own_addr),
    .ten_bit  (ten_bit),
    .hit      (hit)
  );

  i2c_am_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ev_start  (ev_start),
    .ev_rstart (ev_rstart),
    .ev_stop   (ev_stop),
    .ev_byte   (ev_byte),
    .rx_byte   (rx_byte),
    .ten_bit   (ten_bit),
    .hit       (hit),
    .aas       (aas),
    .ack_req   (ack_req),
    .xfer_dir  (xfer_dir),
    .cap_byte  (cap_byte),
    .cap_vld   (cap_vld)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst,
  input logic ev_start,
  input logic ev_rstart,
  input logic ev_stop,
  input logic ev_byte,
  input logic aas,
  input logic ack_req,
  input logic xfer_dir
);
  // R2: the ACK request is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> !ack_req);

  // R2: an ACK request only follows a byte strobe
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> $past(ev_byte));

  // R2: an ACK request comes with the addressed flag
  p_ack_with_aas_r2: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> aas);

  // R7: STOP clears the flag
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !aas);

  // R9: any framing event suppresses an ACK in the following cycle
  p_event_prio_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_stop || ev_start || ev_rstart) |=> !ack_req);

  // R6: direction only moves together with a new match
  p_dir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ack_req |-> $stable(xfer_dir));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_start  (ev_start),
  .ev_rstart (ev_rstart),
  .ev_stop   (ev_stop),
  .ev_byte   (ev_byte),
  .aas       (aas),
  .ack_req   (ack_req),
  .xfer_dir  (xfer_dir)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_waddr = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic       aas, ack_req, xfer_dir;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .aas(aas), .ack_req(ack_req), .xfer_dir(xfer_dir)
  );

  // {mode, own address, header, expected match}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 8'hA4, 8'hA4, 1'b1},
    {1'b0, 8'hA4, 8'hA5, 1'b1},
    {1'b0, 8'hA5, 8'hA4, 1'b1},
    {1'b0, 8'hA4, 8'hA6, 1'b0},
    {1'b0, 8'hA4, 8'h24, 1'b0},
    {1'b1, 8'hF2, 8'hF2, 1'b1},
    {1'b1, 8'hF2, 8'hF3, 1'b0},
    {1'b1, 8'hF3, 8'hF3, 1'b1},
    {1'b1, 8'hF3, 8'hF2, 1'b0},
    {1'b1, 8'hF2, 8'hF6, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic s, input logic rs, input logic sp, input logic by, input logic [7:0] b);
    ev_start = s; ev_rstart = rs; ev_stop = sp; ev_byte = by; rx_byte = b;
    @(negedge clk);
    ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_byte = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 aas", {7'd0, aas}, 8'd0);
    chk("R1 ack", {7'd0, ack_req}, 8'd0);
    rst = 0;
    @(negedge clk);
    rd(2'd2, d); chk("R1 status", d, 8'h00);
    rd(2'd0, d); chk("R1 own", d, 8'h00);
    chk("R1 dir", {7'd0, xfer_dir}, 8'd0);

    // Vector table: R2 (7-bit) and R3 (10-bit)
    for (int i = 0; i < 10; i++) begin
      logic [17:0] v;
      v = VEC[i];
      wr(2'd1, {7'd0, v[17]});
      wr(2'd0, v[16:9]);
      ev(1, 0, 0, 0, 8'h00);
      ev(0, 0, 0, 1, v[8:1]);
      chk(v[17] ? "R3 ack" : "R2 ack", {7'd0, ack_req}, {7'd0, v[0]});
      chk(v[17] ? "R3 aas" : "R2 aas", {7'd0, aas}, {7'd0, v[0]});
      if (v[0]) chk("R2 dir", {7'd0, xfer_dir}, {7'd0, v[1]});
      @(negedge clk);
      chk("R2 ack pulse", {7'd0, ack_req}, 8'd0);
      ev(0, 0, 1, 0, 8'h00);
    end

    // R4 mismatch then ignore, re-arm on repeated START
    wr(2'd1, 8'h00); wr(2'd0, 8'hA4);
    ev(1, 0, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'h10);
    chk("R4 miss ack", {7'd0, ack_req}, 8'd0);
    ev(0, 0, 0, 1, 8'hA4);
    chk("R4 ignored ack", {7'd0, ack_req}, 8'd0);
    chk("R4 ignored aas", {7'd0, aas}, 8'd0);
    ev(0, 1, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'hA4);
    chk("R4 rearm ack", {7'd0, ack_req}, 8'd1);
    // R10 data phase
    @(negedge clk);
    ev(0, 0, 0, 1, 8'hA4);
    chk("R10 data ack", {7'd0, ack_req}, 8'd0);
    chk("R10 data aas", {7'd0, aas}, 8'd1);
    // R7 STOP and START clear
    ev(0, 0, 1, 0, 8'h00);
    chk("R7 stop aas", {7'd0, aas}, 8'd0);
    ev(1, 0, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'hA4);
    chk("R7 match aas", {7'd0, aas}, 8'd1);
    ev(1, 0, 0, 0, 8'h00);
    chk("R7 start aas", {7'd0, aas}, 8'd0);
    ev(0, 0, 1, 0, 8'h00);

    // R5/R6 10-bit flow
    wr(2'd1, 8'h01); wr(2'd0, 8'hF4);
    ev(1, 0, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'hF4);
    chk("R5 hdr ack", {7'd0, ack_req}, 8'd1);
    @(negedge clk);
    ev(0, 0, 0, 1, 8'h5A);
    chk("R5 byte2 no ack", {7'd0, ack_req}, 8'd0);
    rd(2'd3, d); chk("R5 cap", d, 8'h5A);
    rd(2'd2, d); chk("R5 status", d, 8'h05);
    wr(2'd0, 8'hF5);
    ev(0, 1, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'hF5);
    chk("R6 read ack", {7'd0, ack_req}, 8'd1);
    chk("R6 dir", {7'd0, xfer_dir}, 8'd1);
    rd(2'd3, d); chk("R6 cap kept", d, 8'h5A);
    rd(2'd2, d); chk("R6 status", d, 8'h07);
    rd(2'd0, d); chk("R8 own readback", d, 8'hF5);

    // R9 priority
    ev(1, 0, 1, 0, 8'h00);
    chk("R9 stop wins aas", {7'd0, aas}, 8'd0);
    ev(0, 0, 0, 1, 8'hF5);
    chk("R9 idle ignores", {7'd0, ack_req}, 8'd0);
    ev(1, 0, 0, 1, 8'hF5);
    chk("R9 start wins", {7'd0, ack_req}, 8'd0);
    ev(0, 0, 0, 1, 8'hF5);
    chk("R9 header after", {7'd0, ack_req}, 8'd1);
    ev(0, 0, 1, 0, 8'h00);

    // R8 write in the same cycle as a header uses the old value
    ev(1, 0, 0, 0, 8'h00);
    reg_we = 1; reg_waddr = 2'd0; reg_wdata = 8'h20;
    ev(0, 0, 0, 1, 8'h20);
    reg_we = 0;
    chk("R8 old value", {7'd0, ack_req}, 8'd0);
    ev(0, 1, 0, 0, 8'h00);
    ev(0, 0, 0, 1, 8'h20);
    chk("R8 new value", {7'd0, ack_req}, 8'd1);
    rd(2'd1, d); chk("R8 ctrl readback", d, 8'h01);

    finish_run();
  end
endmodule